// File: doc/BRIEF.md
# Unified Block Address Translator

This block maps 32-bit logical addresses onto physical addresses through four block-translation entries. One entry set serves both instruction fetches and data accesses. Each entry holds two 32-bit configuration words, an upper word and a lower word, which software loads through a simple register write port. The upper word carries the logical block tag and the access and protection controls. The lower word carries the physical base, a valid flag and the block-size mask.

Every cycle the translator compares the presented logical address against all valid entries in parallel. The lowest-numbered matching entry is selected. The block registers a hit flag, a 2-bit protection code and the physical address, and presents them one cycle later. The protection code comes from folding the privilege key and the entry's protection bits through a fixed remap table. A set top bit in the segment register that covers the address forces a miss: the caller supplies that bit on `seg_t`.

Top module: `ublk_xlate`

## Requirements
- R1: After synchronous reset every entry is invalid and `hit`, `prot` and `pa` are zero.
- R2: When `cfg_we` is high at a rising edge, `cfg_wdata` is stored into entry `cfg_sel[2:1]`. It goes to the lower word if `cfg_sel[0]` is 1 and to the upper word if it is 0. A lookup presented in the same cycle as a write uses the old contents. The next cycle's lookup uses the new contents.
- R3: An entry takes part in matching only while bit 6 of its lower word is 1. Once that bit is cleared, the entry never hits.
- R4: The block-size field is lower-word bits [5:0]. Logical bits [31:23] are always compared with the upper word. Logical bit 17+i is compared only when block-size bit i is 0. Bits [16:0] are never compared. All other upper-word bits outside [3:0] have no effect.
- R5: On a hit, `pa` takes the compared bit positions from the lower word and every other bit from the logical address.
- R6: With access field A = upper[3:2] and protection field P = upper[1:0], the key is (A[0] and `pr`) or (A[1] and not `pr`). `prot` is entry {key,P} of the table 2,2,2,1,0,1,2,1, indexed 0 to 7.
- R7: When `seg_t` is 1 the lookup misses, whatever the entries hold.
- R8: When several entries match, the lowest-numbered entry supplies `prot` and `pa`.
- R9: On a miss, `prot` and `pa` are zero.
- R10: `hit`, `prot` and `pa` show the result for the `la`, `pr` and `seg_t` sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_sel | input | 3 | Bits [2:1] entry index, bit 0 selects lower (1) or upper (0) word |
| cfg_wdata | input | 32 | Configuration word to store |
| la | input | 32 | Logical address to translate |
| pr | input | 1 | Problem-state (user) privilege bit |
| seg_t | input | 1 | Top bit of the segment register covering `la` |
| hit | output | 1 | Registered translation hit |
| prot | output | 2 | Registered remapped protection code |
| pa | output | 32 | Registered physical address |

## Verification
Every translation result is due exactly one rising edge after its lookup inputs are applied. A configuration write becomes visible to the lookup at the edge after the one that stores it. The bench drives inputs on the falling edge. At each rising edge it first computes the expected result from its model's pre-write entry state, and only then applies any write to the model. It compares all three outputs one nanosecond after that edge. This ordering keeps the same-cycle write case and the one-cycle output latency aligned between the model and the design on every clock.

// File: rtl/ubx_pkg.sv
package ubx_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFF_W   = 17;
  localparam int BSM_W   = 6;
  localparam int VLD_BIT = 6;
  localparam int PROT_W  = 2;

  // Fold privilege key and protection bits to the output code.
  function automatic logic [PROT_W-1:0] remap_prot(input logic key, input logic [1:0] pp);
    logic [2:0] idx;
    idx = {key, pp};
    case (idx)
      3'd0, 3'd1, 3'd2, 3'd6: remap_prot = 2'd2;
      3'd4:                   remap_prot = 2'd0;
      default:                remap_prot = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/ubx_regfile.sv
module ubx_regfile #(
  parameter int NUM_ENT = 4,
  parameter int AW      = 32,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W:0]   sel,
  input  logic [AW-1:0]    wdata,
  output logic [AW-1:0]    upper_o [NUM_ENT],
  output logic [AW-1:0]    lower_o [NUM_ENT]
);
  logic [AW-1:0] upper_q [NUM_ENT];
  logic [AW-1:0] lower_q [NUM_ENT];

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        upper_q[e] <= '0;
        lower_q[e] <= '0;
      end else if (we && (sel[IDX_W:1] == IDX_W'(e))) begin
        if (sel[0]) lower_q[e] <= wdata;
        else        upper_q[e] <= wdata;
      end
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !we |=> ($stable(upper_q[e]) && $stable(lower_q[e])));

    assign upper_o[e] = upper_q[e];
    assign lower_o[e] = lower_q[e];
  end
endmodule

// File: rtl/ubx_entry_match.sv
module ubx_entry_match
  import ubx_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int OW  = OFF_W,
  parameter int BW  = BSM_W,
  parameter int VB  = VLD_BIT,
  localparam int FIX_W = AW - OW - BW
) (
  input  logic [AW-1:0]     upper,
  input  logic [AW-1:0]     lower,
  input  logic [AW-1:0]     la,
  input  logic              pr,
  output logic              match,
  output logic [PROT_W-1:0] prot,
  output logic [AW-1:0]     pa
);
  logic [BW-1:0] bsm;
  logic [AW-1:0] hi_mask;
  logic [1:0]    acc;
  logic [1:0]    pp;
  logic          key;

  assign bsm     = lower[BW-1:0];
  assign hi_mask = {{FIX_W{1'b1}}, ~bsm, {OW{1'b0}}};
  assign acc     = upper[3:2];
  assign pp      = upper[1:0];
  assign key     = (acc[0] & pr) | (acc[1] & ~pr);

  assign match = lower[VB] && ((la & hi_mask) == (upper & hi_mask));
  assign prot  = remap_prot(key, pp);
  assign pa    = (lower & hi_mask) | (la & ~hi_mask);
endmodule

// File: rtl/ubx_prio_sel.sv
module ubx_prio_sel
  import ubx_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int AW      = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_ENT-1:0] match,
  input  logic [PROT_W-1:0] prot_in [NUM_ENT],
  input  logic [AW-1:0]     pa_in   [NUM_ENT],
  input  logic              seg_t,
  output logic              hit_q,
  output logic [PROT_W-1:0] prot_q,
  output logic [AW-1:0]     pa_q
);
  logic [NUM_ENT-1:0] grant;
  logic [PROT_W-1:0]  prot_d;
  logic [AW-1:0]      pa_d;

  always_comb begin
    grant = '0;
    for (int e = 0; e < NUM_ENT; e++) begin
      if (match[e] && (grant == '0)) grant[e] = 1'b1;
    end
    if (seg_t) grant = '0;
  end

  always_comb begin
    prot_d = '0;
    pa_d   = '0;
    for (int e = 0; e < NUM_ENT; e++) begin
      if (grant[e]) begin
        prot_d = prot_in[e];
        pa_d   = pa_in[e];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      prot_q <= '0;
      pa_q   <= '0;
    end else begin
      hit_q  <= |grant;
      prot_q <= prot_d;
      pa_q   <= pa_d;
    end
  end

  // R8
  grant_single_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (grant == '0) |=> (!hit_q && prot_q == '0 && pa_q == '0));
endmodule

// File: rtl/ublk_xlate.sv
module ublk_xlate
  import ubx_pkg::*;
#(
  parameter int NUM_ENT = 4,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W:0]    cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] la,
  input  logic              pr,
  input  logic              seg_t,
  output logic              hit,
  output logic [PROT_W-1:0] prot,
  output logic [ADDR_W-1:0] pa
);
  logic [ADDR_W-1:0]  upper_w [NUM_ENT];
  logic [ADDR_W-1:0]  lower_w [NUM_ENT];
  logic [NUM_ENT-1:0] match_w;
  logic [NUM_ENT-1:0] vld_w;
  logic [PROT_W-1:0]  prot_w  [NUM_ENT];
  logic [ADDR_W-1:0]  pa_w    [NUM_ENT];

  ubx_regfile #(.NUM_ENT(NUM_ENT), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .upper_o(upper_w), .lower_o(lower_w)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_match
    ubx_entry_match u_ent (
      .upper(upper_w[e]), .lower(lower_w[e]), .la(la), .pr(pr),
      .match(match_w[e]), .prot(prot_w[e]), .pa(pa_w[e])
    );
    assign vld_w[e] = lower_w[e][VLD_BIT];
  end

  ubx_prio_sel #(.NUM_ENT(NUM_ENT), .AW(ADDR_W)) u_sel (
    .clk(clk), .rst(rst), .match(match_w), .prot_in(prot_w), .pa_in(pa_w),
    .seg_t(seg_t), .hit_q(hit), .prot_q(prot), .pa_q(pa)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!hit && prot == '0 && pa == '0));

  // R7
  seg_force_miss_chk: assert property (@(posedge clk) disable iff (rst)
    seg_t |=> !hit);

  // R3
  no_valid_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_w == '0) |=> !hit);

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (pa[OFF_W-1:0] == $past(la[OFF_W-1:0])));

  // R6
  prot_range_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (prot != 2'd3));
endmodule

// File: tb/ublk_xlate_bench.sv
`timescale 1ns/1ps
module ublk_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] la = '0;
  logic        pr = 1'b0;
  logic        seg_t = 1'b0;
  logic        hit;
  logic [1:0]  prot;
  logic [31:0] pa;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_up [4];
  logic [31:0] m_lo [4];
  int conv [8] = '{2, 2, 2, 1, 0, 1, 2, 1};

  always #2 clk = ~clk;

  ublk_xlate u_ublk_xlate (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .la(la), .pr(pr), .seg_t(seg_t), .hit(hit), .prot(prot), .pa(pa)
  );

  task automatic model(input logic [31:0] a, input logic p, input logic t,
                       output logic h, output logic [1:0] pc, output logic [31:0] ph);
    h = 1'b0; pc = 2'd0; ph = 32'd0;
    for (int e = 0; e < 4; e++) begin
      logic [31:0] msk;
      int k;
      msk = ~((32'(m_lo[e][5:0]) << 17) | 32'h1FFFF);
      if (!h && m_lo[e][6] && ((a & msk) == (m_up[e] & msk))) begin
        h = 1'b1;
        k = (m_up[e][2] && p) || (m_up[e][3] && !p) ? 1 : 0;
        pc = 2'(conv[k * 4 + int'(m_up[e][1:0])]);
        ph = (m_lo[e] & msk) | (a & ~msk);
      end
    end
    if (t) begin h = 1'b0; pc = 2'd0; ph = 32'd0; end
  endtask

  task automatic step(input logic we, input logic [2:0] sel, input logic [31:0] wd,
                      input logic [31:0] a, input logic p, input logic t, input string req);
    logic eh; logic [1:0] ep; logic [31:0] ea;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd; la = a; pr = p; seg_t = t;
    @(posedge clk);
    model(a, p, t, eh, ep, ea);
    if (we) begin
      if (sel[0]) m_lo[sel[2:1]] = wd;
      else        m_up[sel[2:1]] = wd;
    end
    #1;
    n_vec++;
    if (hit !== eh || prot !== ep || pa !== ea) begin
      n_bad++;
      $display("FAIL %s: got hit=%b prot=%0d pa=%08h, expected hit=%b prot=%0d pa=%08h",
               req, hit, prot, pa, eh, ep, ea);
    end
  endtask

  task automatic lit(input logic eh, input logic [1:0] ep, input logic [31:0] ea, input string req);
    n_vec++;
    if (hit !== eh || prot !== ep || pa !== ea) begin
      n_bad++;
      $display("FAIL %s: got hit=%b prot=%0d pa=%08h, expected hit=%b prot=%0d pa=%08h",
               req, hit, prot, pa, eh, ep, ea);
    end
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 4; e++) begin m_up[e] = '0; m_lo[e] = '0; end
    repeat (4) @(posedge clk);
    #1;
    lit(1'b0, 2'd0, 32'd0, "R1 reset outputs");
    @(negedge clk); rst = 1'b0;
    step(0, 3'b000, 0, 32'h8001_2345, 1'b0, 1'b0, "R1 empty table");

    // R2: program entry 0, lookup in same cycle as lower write sees old state
    step(1, 3'b000, 32'h8000_0006, 32'h8001_2345, 1'b1, 1'b0, "R2 upper write");
    step(1, 3'b001, 32'h0010_0040, 32'h8001_2345, 1'b1, 1'b0, "R2 same-cycle old state");
    step(0, 3'b000, 0, 32'h8001_2345, 1'b1, 1'b0, "R2 next-cycle new state");
    lit(1'b1, 2'd2, 32'h0011_2345, "R5 literal pa");
    step(0, 3'b000, 0, 32'h8003_0000, 1'b1, 1'b0, "R9 miss outside block");
    lit(1'b0, 2'd0, 32'd0, "R9 literal miss zeros");

    // R6: sweep access and protection fields with both privilege levels
    for (int ap = 0; ap < 16; ap++) begin
      step(1, 3'b000, 32'h8000_0000 | 32'(ap), 32'h8000_0100, 1'b0, 1'b0, "R6 reprogram");
      step(0, 3'b000, 0, 32'h8000_0100, 1'b0, 1'b0, "R6 supervisor key");
      step(0, 3'b000, 0, 32'h8000_0100, 1'b1, 1'b0, "R6 user key");
    end
    step(1, 3'b000, 32'h8000_000C, 32'h8000_0100, 1'b0, 1'b0, "R6 reprogram");
    step(0, 3'b000, 0, 32'h8000_0100, 1'b1, 1'b0, "R6 literal");
    lit(1'b1, 2'd0, 32'h0010_0100, "R6 key1 pp0 gives 0");

    // R4: large block with stray upper bits, and a small block
    step(1, 3'b010, 32'h4012_3456, 32'h0, 1'b0, 1'b0, "R4 upper");
    step(1, 3'b011, 32'h0200_007F, 32'h0, 1'b0, 1'b0, "R4 lower");
    step(0, 3'b000, 0, 32'h407F_FFFF, 1'b0, 1'b0, "R4 max block inside");
    lit(1'b1, 2'd2, 32'h027F_FFFF, "R4 literal large block");
    step(0, 3'b000, 0, 32'h4080_0000, 1'b0, 1'b0, "R4 max block outside");
    step(1, 3'b100, 32'h2000_000E, 32'h0, 1'b0, 1'b0, "R4 upper");
    step(1, 3'b101, 32'h0300_0041, 32'h0, 1'b0, 1'b0, "R4 lower");
    step(0, 3'b000, 0, 32'h2002_0000, 1'b0, 1'b0, "R4 masked bit17");
    step(0, 3'b000, 0, 32'h2004_0000, 1'b0, 1'b0, "R4 compared bit18");

    // R8: overlap entries 2 and 3
    step(1, 3'b110, 32'h2000_0002, 32'h0, 1'b0, 1'b0, "R8 upper");
    step(1, 3'b111, 32'h0400_0040, 32'h0, 1'b0, 1'b0, "R8 lower");
    step(0, 3'b000, 0, 32'h2000_1000, 1'b0, 1'b0, "R8 lowest index wins");
    lit(1'b1, 2'd2, 32'h0300_1000, "R8 literal");
    // R7
    step(0, 3'b000, 0, 32'h2000_1000, 1'b0, 1'b1, "R7 segment forced miss");
    // R3: invalidate entry 2, entry 3 now answers
    step(1, 3'b101, 32'h0300_0001, 32'h2000_1000, 1'b0, 1'b0, "R3 clear valid");
    step(0, 3'b000, 0, 32'h2000_1000, 1'b0, 1'b0, "R3 invalid entry skipped");
    lit(1'b1, 2'd2, 32'h0400_1000, "R3 literal");

    // R10 and mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] pre [4];
      logic [31:0] rw;
      logic [31:0] ra;
      pre = '{32'h8000_0000, 32'h4000_0000, 32'h2000_0000, 32'hF000_0000};
      rw = $urandom;
      ra = pre[$urandom_range(0, 3)] | ($urandom & 32'h00FF_FFFF);
      if ($urandom_range(0, 4) == 0) begin
        logic [2:0] s;
        s = 3'($urandom_range(0, 7));
        if (!s[0]) rw = pre[$urandom_range(0, 3)] | (rw & 32'h00FF_FFFF);
        step(1, s, rw, ra, 1'($urandom), 1'($urandom_range(0, 7) == 0), "R10 random write");
      end else begin
        step(0, 3'b000, 0, ra, 1'($urandom), 1'($urandom_range(0, 7) == 0), "R10 random lookup");
      end
    end

    @(negedge clk); cfg_we = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule